// File: doc/BRIEF.md
# Compare Match Interval Timer

A single-channel interval timer for periodic event generation. A 16-bit up-counter advances once per prescaler tick and is compared with a programmable constant. The prescaler divides the peripheral clock by 8, 32, 128 or 512. When the counter already equals the constant at a tick, it wraps to zero instead of incrementing, and a sticky match flag is raised. An interrupt request follows the flag when the interrupt enable is set.

Software drives the timer through a four-entry register interface: a start register, a control/status register, the counter and the constant. Writes take effect at the next clock edge. Reads are combinational. A read strobe is needed only to arm the flag-clear sequence.

Two standby inputs give different behaviour:
- Software standby wipes the counter and the prescaler.
- Module standby freezes both and keeps their values.

Stopping the timer by writing its start bit from 1 to 0 also zeroes the counter.

Top module: `cmt_timer`

## Requirements
- R1: On a tick where the counter equals the constant and no counter write occurs, the counter becomes 0x0000 at the next edge and the match flag (control/status bit 7) becomes 1.
- R2: On a tick where the counter differs from the constant and no counter write occurs, the counter increments by one.
- R3: Writing 0 to start bit 0 (address 0) while the timer runs clears the counter to 0x0000.
- R4: After synchronous reset, the start bit is 0, the counter is 0x0000, the constant is 0xFFFF, the control/status register reads 0, and irq is 0.
- R5: While sw_stby is high, the counter and prescaler are cleared and no ticks occur.
- R6: While mod_stby is high, the counter and prescaler hold their values. Counting resumes from them afterwards.
- R7: Control/status bits 1:0 select the tick period: 0 selects 8 clocks, 1 selects 32, 2 selects 128 and 3 selects 512. The prescaler is cleared while the start bit is 0.
- R8: The flag clears only when a write with bit 7 = 0 follows a read (bus_rd) of the control/status register that returned the flag as 1. A write of 0 without that read leaves the flag at 1. A match in the same cycle as the clearing write leaves the flag at 1.
- R9: irq is high exactly when the flag is 1 and the interrupt enable (control/status bit 6) is 1.
- R10: A write to the counter (address 2) overrides both counting and the match wrap in that cycle, and raises no flag.
- R11: The register map is address 0 = start, 1 = control/status, 2 = counter, 3 = constant. Each register reads back what it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sw_stby | input | 1 | Software standby: clears counter and prescaler |
| mod_stby | input | 1 | Module standby: freezes counter and prescaler |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flag clear) |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational |
| irq | output | 1 | Compare-match interrupt request |

## Verification
The bench uses the default parameters: a 16-bit counter and a prescaler base of divide-by-8 with a factor-of-4 step. Small constants therefore wrap within tens of cycles, and even the 512-clock select finishes in about a thousand cycles. All four divide ratios and a constant of zero are covered, with wrap counts computed from tick totals. Because the divide-by-8 period is short, edge-exact alignment is possible. That alignment places a counter write and a flag-clear write on the same edge as a tick, and those collisions decide R8 and R10.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_CSR   = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_CONST = 2'd3
    } reg_sel_e;

    localparam int CSR_FLAG_BIT = 7;
    localparam int CSR_IE_BIT   = 6;
    localparam int CLK_SEL_W    = 2;

    typedef struct packed {
        logic                 flag;
        logic                 ie;
        logic [CLK_SEL_W-1:0] clk_sel;
    } csr_t;

    function automatic int div_log2(input int base, input int step, input int sel);
        return base + step * sel;
    endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
    import cmt_pkg::*;
#(
    parameter int BASE_LOG2 = 3,
    parameter int STEP_LOG2 = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 sw_stby,
    input  logic                 mod_stby,
    input  logic [CLK_SEL_W-1:0] clk_sel,
    output logic                 tick
);
    localparam int NUM_DIV = 1 << CLK_SEL_W;
    localparam int PRE_W   = div_log2(BASE_LOG2, STEP_LOG2, NUM_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask_tab [NUM_DIV];
    logic [PRE_W-1:0] sel_mask;

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_mask
        assign mask_tab[g] = {PRE_W{1'b1}} >> (PRE_W - div_log2(BASE_LOG2, STEP_LOG2, g));
    end

    assign sel_mask = mask_tab[clk_sel];

    always_ff @(posedge clk) begin
        if (rst || !start || sw_stby) begin
            pre_q <= '0;
        end else if (!mod_stby) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = start && !sw_stby && !mod_stby && ((pre_q & sel_mask) == sel_mask);

    // R7: a stopped prescaler restarts from zero
    assert_pre_stop_R7: assert property (@(posedge clk) disable iff (rst)
        !start |=> (pre_q == '0));

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             stop,
    input  logic             sw_stby,
    input  logic             mod_stby,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             match_evt
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_const;

    assign at_const  = (cnt_q == cmp);
    assign match_evt = tick && !cnt_wr && !sw_stby && at_const;

    always_ff @(posedge clk) begin
        if (rst || sw_stby || stop) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= wdata;
        end else if (tick) begin
            cnt_q <= at_const ? '0 : cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

    assert_match_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && !sw_stby && (cnt_q == cmp)) |=> (cnt_q == '0));
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && !stop && !sw_stby && (cnt_q != cmp)) |=> (cnt_q == $past(cnt_q) + 1'b1));
    assert_stop_clear_R3: assert property (@(posedge clk) disable iff (rst)
        stop |=> (cnt_q == '0));
    assert_sw_standby_clear_R5: assert property (@(posedge clk) disable iff (rst)
        sw_stby |=> (cnt_q == '0));
    assert_mod_standby_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mod_stby && !sw_stby && !stop && !cnt_wr) |=> $stable(cnt_q));
    assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && !sw_stby) |=> (cnt_q == $past(wdata)));

endmodule

// File: rtl/cmt_regs.sv
module cmt_regs
    import cmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [CNT_W-1:0]     bus_wdata,
    input  logic [CNT_W-1:0]     cnt,
    input  logic                 match_evt,
    output logic                 start,
    output logic [CLK_SEL_W-1:0] clk_sel,
    output logic [CNT_W-1:0]     cmp,
    output logic                 cnt_wr,
    output logic                 stop,
    output logic [CNT_W-1:0]     bus_rdata,
    output logic                 irq
);
    reg_sel_e         sel;
    csr_t             csr_q;
    logic             start_q;
    logic             seen_q;
    logic [CNT_W-1:0] cmp_q;
    logic             csr_wr;
    logic             flag_clr;

    assign sel      = reg_sel_e'(bus_addr);
    assign csr_wr   = bus_wr && (sel == SEL_CSR);
    assign flag_clr = csr_wr && !bus_wdata[CSR_FLAG_BIT] && seen_q;
    assign cnt_wr   = bus_wr && (sel == SEL_COUNT);
    assign stop     = bus_wr && (sel == SEL_START) && !bus_wdata[0] && start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            csr_q   <= '0;
            seen_q  <= 1'b0;
            cmp_q   <= '1;
        end else begin
            if (bus_wr && (sel == SEL_START)) start_q <= bus_wdata[0];
            if (bus_wr && (sel == SEL_CONST)) cmp_q <= bus_wdata;
            if (csr_wr) begin
                csr_q.ie      <= bus_wdata[CSR_IE_BIT];
                csr_q.clk_sel <= bus_wdata[CLK_SEL_W-1:0];
                seen_q        <= 1'b0;
            end else if (bus_rd && (sel == SEL_CSR) && csr_q.flag) begin
                seen_q <= 1'b1;
            end
            if (match_evt)     csr_q.flag <= 1'b1;
            else if (flag_clr) csr_q.flag <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_START: bus_rdata[0] = start_q;
            SEL_CSR: begin
                bus_rdata[CSR_FLAG_BIT]    = csr_q.flag;
                bus_rdata[CSR_IE_BIT]      = csr_q.ie;
                bus_rdata[CLK_SEL_W-1:0]   = csr_q.clk_sel;
            end
            SEL_COUNT: bus_rdata = cnt;
            default:   bus_rdata = cmp_q;
        endcase
    end

    assign start   = start_q;
    assign clk_sel = csr_q.clk_sel;
    assign cmp     = cmp_q;
    assign irq     = csr_q.flag && csr_q.ie;

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        match_evt |=> csr_q.flag);
    assert_clear_needs_read_R8: assert property (@(posedge clk) disable iff (rst)
        (csr_q.flag && !seen_q) |=> csr_q.flag);
    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (!csr_q.flag && !match_evt) |=> !irq);

endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int BASE_LOG2 = 3,
    parameter int STEP_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_stby,
    input  logic             mod_stby,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);
    logic                 start;
    logic [CLK_SEL_W-1:0] clk_sel;
    logic [CNT_W-1:0]     cmp;
    logic [CNT_W-1:0]     cnt;
    logic                 cnt_wr;
    logic                 stop;
    logic                 tick;
    logic                 match_evt;

    cmt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .cnt(cnt), .match_evt(match_evt), .start(start),
        .clk_sel(clk_sel), .cmp(cmp), .cnt_wr(cnt_wr), .stop(stop),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    cmt_prescaler #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2)) u_pre (
        .clk(clk), .rst(rst), .start(start), .sw_stby(sw_stby), .mod_stby(mod_stby),
        .clk_sel(clk_sel), .tick(tick)
    );

    cmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .stop(stop), .sw_stby(sw_stby),
        .mod_stby(mod_stby), .cnt_wr(cnt_wr), .wdata(bus_wdata), .cmp(cmp),
        .cnt(cnt), .match_evt(match_evt)
    );

endmodule

// File: tb/cmt_timer_test.sv
module cmt_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    // cmp, clock select, ticks, expected count, expected flag
    localparam int VEC [7][5] = '{
        '{5,   0, 3,  3,  0},
        '{5,   0, 6,  0,  1},
        '{5,   0, 8,  2,  1},
        '{0,   0, 4,  0,  1},
        '{100, 1, 10, 10, 0},
        '{3,   2, 5,  1,  1},
        '{3,   3, 2,  2,  0}
    };

    logic clk = 0, rst = 1, sw_stby = 0, mod_stby = 0;
    logic [1:0] bus_addr = 0;
    logic bus_wr = 0, bus_rd = 0;
    logic [W-1:0] bus_wdata = 0;
    logic [W-1:0] bus_rdata;
    logic irq;
    int errors = 0, checks = 0;
    logic done = 0;

    cmt_timer uut (.clk(clk), .rst(rst), .sw_stby(sw_stby), .mod_stby(mod_stby),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        @(posedge clk); #1;
        bus_rd = 0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [W-1:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic clear_flag(input logic [1:0] csel);
        rd(2'd1);
        wr(2'd1, {14'd0, csel});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R4 reset state, R11 map
        peek(2'd0, v); check("R4 start", v, 0);
        peek(2'd1, v); check("R4 csr", v, 0);
        peek(2'd2, v); check("R4 count", v, 0);
        peek(2'd3, v); check("R4 const", v, 16'hFFFF);
        check("R4 irq", {15'd0, irq}, 0);

        // R1 R2 R7 vector table
        for (int i = 0; i < 7; i++) begin
            wr(2'd0, 0);
            clear_flag(VEC[i][1][1:0]);
            wr(2'd3, VEC[i][0][W-1:0]);
            wr(2'd0, 1);
            repeat (VEC[i][2] * (8 << (2 * VEC[i][1]))) @(posedge clk);
            #1;
            peek(2'd2, v); check("R1/R2/R7 vector count", v, VEC[i][3][W-1:0]);
            peek(2'd1, v); check("R1 vector flag", {15'd0, v[7]}, VEC[i][4][W-1:0]);
        end

        // R11 constant readback
        wr(2'd3, 16'hA5C3);
        peek(2'd3, v); check("R11 const readback", v, 16'hA5C3);

        // R3 stop clears counter
        wr(2'd0, 0); clear_flag(0); wr(2'd3, 100);
        wr(2'd0, 1);
        repeat (24) @(posedge clk); #1;
        peek(2'd2, v); check("R3 pre-stop count", v, 3);
        wr(2'd0, 0);
        peek(2'd2, v); check("R3 stop clears", v, 0);

        // R6 module standby holds
        wr(2'd0, 1);
        repeat (24) @(posedge clk);
        @(negedge clk); mod_stby = 1;
        repeat (100) @(posedge clk);
        @(negedge clk); mod_stby = 0;
        peek(2'd2, v); check("R6 hold in module standby", v, 3);
        repeat (16) @(posedge clk); #1;
        peek(2'd2, v); check("R6 resume after standby", v, 5);

        // R5 software standby clears
        @(negedge clk); sw_stby = 1;
        repeat (20) @(posedge clk);
        @(negedge clk); sw_stby = 0;
        peek(2'd2, v); check("R5 sw standby clears", v, 0);

        // R10 counter write beats counting on a tick edge
        wr(2'd0, 0); wr(2'd3, 16'h2000);
        wr(2'd0, 1);
        repeat (7) @(posedge clk);
        wr(2'd2, 16'h1234);
        peek(2'd2, v); check("R10 write beats count", v, 16'h1234);
        repeat (8) @(posedge clk); #1;
        peek(2'd2, v); check("R10 counting resumes", v, 16'h1235);

        // R10 write beats match wrap, no flag
        wr(2'd0, 0); clear_flag(0); wr(2'd3, 2);
        wr(2'd0, 1);
        repeat (23) @(posedge clk);
        wr(2'd2, 7);
        peek(2'd2, v); check("R10 write beats wrap", v, 7);
        peek(2'd1, v); check("R10 no flag", {15'd0, v[7]}, 0);

        // R8 clear without read ignored; set wins; R9 irq
        wr(2'd0, 0); clear_flag(0); wr(2'd3, 0);
        wr(2'd1, 16'h0040);
        wr(2'd0, 1);
        repeat (8) @(posedge clk); #1;
        check("R9 irq with flag and enable", {15'd0, irq}, 1);
        wr(2'd1, 16'h0040);
        peek(2'd1, v); check("R8 clear without read ignored", {15'd0, v[7]}, 1);
        wr(2'd0, 0); clear_flag(0);
        peek(2'd1, v); check("R8 read then write clears", {15'd0, v[7]}, 0);
        check("R9 irq low after clear", {15'd0, irq}, 0);
        wr(2'd0, 1);
        repeat (8) @(posedge clk);
        rd(2'd1);
        repeat (6) @(posedge clk);
        wr(2'd1, 0);
        peek(2'd1, v); check("R8 set wins over clear", {15'd0, v[7]}, 1);
        check("R9 irq off when disabled", {15'd0, irq}, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule